// File: doc/BRIEF.md
# Serial ADC Word Deserializer

This block turns one source-synchronous serial data lane from an analog-to-digital converter into parallel 12-bit sample words. The lane is captured at double data rate, so every bit-clock cycle delivers two bits. These bits are presented as a 2-bit bus. The bits are collected into two 6-bit halves. The first half becomes the upper part of the word, and the two halves are joined into one word per frame. A frame marker that travels with the data marks the start of each word.

For link bring-up the converter is set to send a fixed test word, and the training input is raised. Each received word that differs from the expected pattern delays the capture point by one more bit. When enough matching words arrive in a row, the block raises its aligned flag. After that, normal traffic flows through the same path with the alignment found during training.

Top module: `adc_word_deser`

## Requirements
- R1: Within each received pair, `ddr_bits[1]` is the earlier serial bit and `ddr_bits[0]` the later one. Words are sent MSB first, so the pair sampled with the frame rise supplies word bits 11 and 10.
- R2: The first three pairs of a word fill the upper half, bits [11:6]. The next three pairs fill the lower half, bits [5:0].
- R3: `word_valid` is high for exactly one cycle per word, in the cycle after the clock edge that captured the word's last pair. `word_out` keeps that word until the next one.
- R4: A word starts only where `frame_in` is sampled high after having been sampled low at the previous edge. A marker held high for several pairs does not restart the word.
- R5: A frame rise in the middle of a word drops the partial word, and no valid is produced for it. The pair sampled with the rise becomes the first pair of a new upper half.
- R6: After reset, no word is presented until the first frame rise has been seen.
- R7: While `train_en` is low, received words are not compared. The capture offset and the aligned flag stay unchanged.
- R8: While `train_en` is high, every completed word that differs from PATTERN (default 12'hA5C) delays capture by one more bit, wrapping from 11 back to 0. The new offset applies from the next word onward, and the mismatch also clears the aligned flag and the match count.
- R9: In training, eight consecutive words equal to PATTERN set `aligned`. The flag is visible in the same cycle as the eighth word's valid.
- R10: A clock edge with `rst_n` low clears `word_valid`, `word_out`, `aligned`, the partial word and the capture offset, leaving the offset at zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one rising edge per received bit pair |
| rst_n | input | 1 | Synchronous reset, active low |
| ddr_bits | input | 2 | Bit pair from the double-data-rate capture, earlier bit in bit 1 |
| frame_in | input | 1 | Frame marker sent with the data; its rising edge marks a word start |
| train_en | input | 1 | Enables comparison against the test pattern and bit slipping |
| word_out | output | 12 | Last assembled sample word |
| word_valid | output | 1 | One-cycle strobe for a new word on `word_out` |
| aligned | output | 1 | Set after eight consecutive pattern matches in training |

## Verification
The bench builds the block with its default parameters: 12-bit words, 6-bit halves, 2-bit pairs, a lock count of eight and the pattern 12'hA5C. The lane is driven with a 5-bit skew between data and frame, an odd value that forces the single-bit part of the slip to act. Training then has to step through five rotated mismatches before it can lock. The 12-bit width keeps the full wrap of the offset and the eight-word lock run within a few hundred cycles. This also leaves room to inject a corrupted word after lock and to reset the block while it is locked.

// File: rtl/adc_deser_pkg.sv
// Package: shared constants and types for the serial ADC word deserializer.
// Assumes: nothing; holds defaults only, every module takes them as parameters.
package adc_deser_pkg;

    localparam int DEF_WORD_W   = 12;
    localparam int DEF_HALF_W   = 6;
    localparam int DEF_LANE_W   = 2;
    localparam int DEF_LOCK_CNT = 8;
    localparam logic [DEF_WORD_W-1:0] DEF_PATTERN = 12'hA5C;

    // Which half of the word is currently being gathered.
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_e;

endpackage

// File: rtl/adc_lane_capture.sv
// Module: adc_lane_capture
// Registers each bit pair into a short history of the serial stream, and
// registers the frame marker to find its rising edge.
// Assumes: ddr_bits[LANE_W-1] is the earliest bit of the pair; the newest
// bit of the stream ends up in hist[0], older bits at higher indices.
module adc_lane_capture #(
    parameter int LANE_W = 2,
    parameter int HIST_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] ddr_bits,
    input  logic              frame_in,
    output logic [HIST_W-1:0] hist,
    output logic              frame_rise
);

    logic frame_q;
    logic frame_p;

    // Stream history: shift in one pair per cycle, older bits move up.
    generate
        if (HIST_W > LANE_W) begin : g_hist_long
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= {hist[HIST_W-LANE_W-1:0], ddr_bits};
            end
        end else begin : g_hist_short
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= ddr_bits;
            end
        end
    endgenerate

    // Frame marker: sample it and keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            frame_p <= 1'b0;
        end else begin
            frame_q <= frame_in;
            frame_p <= frame_q;
        end
    end

    assign frame_rise = frame_q & ~frame_p;

    // A rising edge of the marker lasts a single cycle.
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rise |=> !frame_rise);

endmodule

// File: rtl/adc_bit_slip.sv
// Module: adc_bit_slip
// Chooses the bit pair that lies a given number of bits back in the stream
// history, so capture can be delayed one bit at a time.
// Assumes: off never exceeds MAX_OFF, and HIST_W covers LANE_W + MAX_OFF bits.
module adc_bit_slip #(
    parameter int LANE_W  = 2,
    parameter int MAX_OFF = 11,
    parameter int HIST_W  = LANE_W + MAX_OFF,
    parameter int OFF_W   = 4
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [OFF_W-1:0]  off,
    output logic [LANE_W-1:0] pair
);

    // Offset mux: one candidate window per possible delay.
    always_comb begin
        pair = '0;
        for (int k = 0; k <= MAX_OFF; k++) begin
            if (off == OFF_W'(k)) pair = hist[k +: LANE_W];
        end
    end

endmodule

// File: rtl/adc_half_assembler.sv
// Module: adc_half_assembler
// Gathers aligned pairs into two halves (upper half first, MSB first) and
// joins them into a word; a frame rise restarts gathering at the upper half.
// Assumes: HALF_W is a multiple of LANE_W and at least twice LANE_W.
// Words are presented only after the first frame rise since reset.
module adc_half_assembler
    import adc_deser_pkg::*;
#(
    parameter int LANE_W = 2,
    parameter int HALF_W = 6,
    parameter int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] pair,
    input  logic              frame_rise,
    output logic              word_done,
    output logic [WORD_W-1:0] word_next,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    localparam int PAIRS  = HALF_W / LANE_W;
    localparam int PCNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int SR_W   = HALF_W - LANE_W;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] eff_pcnt;
    half_e             half_sel;
    half_e             eff_half;
    logic [SR_W-1:0]   half_sr;
    logic [HALF_W-1:0] upper_q;
    logic [HALF_W-1:0] half_now;
    logic              half_full;
    logic              synced;

    // Effective position: a frame rise forces the first pair of an upper half.
    always_comb begin
        eff_pcnt  = frame_rise ? '0 : pcnt;
        eff_half  = frame_rise ? HALF_UPPER : half_sel;
        half_full = (eff_pcnt == PCNT_W'(PAIRS - 1));
        half_now  = {half_sr, pair};
    end

    assign word_next = {upper_q, half_now};
    assign word_done = half_full && (eff_half == HALF_LOWER) && synced;

    // Half shift register: keeps the pairs received so far in this half.
    generate
        if (SR_W > LANE_W) begin : g_sr_long
            always_ff @(posedge clk) begin
                if (!rst_n) half_sr <= '0;
                else        half_sr <= {half_sr[SR_W-LANE_W-1:0], pair};
            end
        end else begin : g_sr_one
            always_ff @(posedge clk) begin
                if (!rst_n) half_sr <= '0;
                else        half_sr <= pair;
            end
        end
    endgenerate

    // Position tracking: pair count, half select, stored upper half, sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt     <= '0;
            half_sel <= HALF_UPPER;
            upper_q  <= '0;
            synced   <= 1'b0;
        end else begin
            if (frame_rise) synced <= 1'b1;
            if (half_full) begin
                pcnt <= '0;
                if (eff_half == HALF_UPPER) begin
                    upper_q  <= half_now;
                    half_sel <= HALF_LOWER;
                end else begin
                    half_sel <= HALF_UPPER;
                end
            end else begin
                pcnt     <= eff_pcnt + 1'b1;
                half_sel <= eff_half;
            end
        end
    end

    // Output register: present a finished word with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= word_done;
            if (word_done) word_out <= word_next;
        end
    end

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    p_no_word_unsynced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !word_valid);

    p_restart_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rise |=> (half_sel == HALF_UPPER));

endmodule

// File: rtl/adc_align_trainer.sv
// Module: adc_align_trainer
// In training, compares each finished word with the test pattern. A mismatch
// adds one bit of capture delay (wrapping), and a run of matches sets aligned.
// Assumes: word_done is high for one cycle per word, with word_next valid then.
module adc_align_trainer #(
    parameter int WORD_W   = 12,
    parameter int MAX_OFF  = 11,
    parameter int OFF_W    = 4,
    parameter int LOCK_CNT = 8,
    parameter logic [WORD_W-1:0] PATTERN = 12'hA5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_en,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_next,
    output logic [OFF_W-1:0]  slip_off,
    output logic              aligned
);

    localparam int CNT_W = $clog2(LOCK_CNT + 1);

    logic [CNT_W-1:0] match_cnt;
    logic             judge;

    assign judge = train_en && word_done;

    // Training state: offset, consecutive-match count and aligned flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slip_off  <= '0;
            match_cnt <= '0;
            aligned   <= 1'b0;
        end else if (judge) begin
            if (word_next != PATTERN) begin
                slip_off  <= (slip_off == OFF_W'(MAX_OFF)) ? '0 : slip_off + 1'b1;
                match_cnt <= '0;
                aligned   <= 1'b0;
            end else if (match_cnt < CNT_W'(LOCK_CNT)) begin
                match_cnt <= match_cnt + 1'b1;
                if (match_cnt == CNT_W'(LOCK_CNT - 1)) aligned <= 1'b1;
            end
        end
    end

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !train_en |=> ($stable(slip_off) && $stable(aligned)));

    p_slip_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slip_off) |-> (($past(slip_off) == OFF_W'(MAX_OFF)) ?
                                (slip_off == '0) :
                                (slip_off == $past(slip_off) + 1'b1)));

    p_lock_in_training_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(train_en));

    p_locked_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && $past(aligned)) |-> $stable(slip_off));

endmodule

// File: rtl/adc_word_deser.sv
// Module: adc_word_deser (top)
// Serial ADC word deserializer. Pairs flow through capture, the bit-slip mux
// and the half assembler; the trainer steers the slip offset from the words.
// Assumes: one clk edge per DDR bit pair, and frame_in synchronous to clk.
module adc_word_deser
    import adc_deser_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int HALF_W   = DEF_HALF_W,
    parameter int LANE_W   = DEF_LANE_W,
    parameter int LOCK_CNT = DEF_LOCK_CNT,
    parameter logic [WORD_W-1:0] PATTERN = DEF_PATTERN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] ddr_bits,
    input  logic              frame_in,
    input  logic              train_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              aligned
);

    localparam int MAX_OFF = WORD_W - 1;
    localparam int HIST_W  = LANE_W + MAX_OFF;
    localparam int OFF_W   = $clog2(WORD_W);

    logic [HIST_W-1:0] hist;
    logic              frame_rise;
    logic [OFF_W-1:0]  slip_off;
    logic [LANE_W-1:0] pair;
    logic              word_done;
    logic [WORD_W-1:0] word_next;

    adc_lane_capture #(
        .LANE_W (LANE_W),
        .HIST_W (HIST_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .ddr_bits   (ddr_bits),
        .frame_in   (frame_in),
        .hist       (hist),
        .frame_rise (frame_rise)
    );

    adc_bit_slip #(
        .LANE_W  (LANE_W),
        .MAX_OFF (MAX_OFF),
        .HIST_W  (HIST_W),
        .OFF_W   (OFF_W)
    ) u_slip (
        .hist (hist),
        .off  (slip_off),
        .pair (pair)
    );

    adc_half_assembler #(
        .LANE_W (LANE_W),
        .HALF_W (HALF_W),
        .WORD_W (WORD_W)
    ) u_assemble (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair       (pair),
        .frame_rise (frame_rise),
        .word_done  (word_done),
        .word_next  (word_next),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    adc_align_trainer #(
        .WORD_W   (WORD_W),
        .MAX_OFF  (MAX_OFF),
        .OFF_W    (OFF_W),
        .LOCK_CNT (LOCK_CNT),
        .PATTERN  (PATTERN)
    ) u_train (
        .clk       (clk),
        .rst_n     (rst_n),
        .train_en  (train_en),
        .word_done (word_done),
        .word_next (word_next),
        .slip_off  (slip_off),
        .aligned   (aligned)
    );

endmodule

// File: tb/adc_word_deser_test.sv
module adc_word_deser_test;

    localparam logic [11:0] PAT = 12'hA5C;

    typedef struct packed {
        logic [11:0] stim;
        logic [11:0] expect_w;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{12'hA5C, 12'hA5C}, '{12'h000, 12'h000}, '{12'hFFF, 12'hFFF},
        '{12'h801, 12'h801}, '{12'h3C6, 12'h3C6}, '{12'h555, 12'h555},
        '{12'hAAA, 12'hAAA}, '{12'h123, 12'h123}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ddr_bits = '0;
    logic        frame_in = 1'b0;
    logic        train_en = 1'b0;
    logic [11:0] word_out;
    logic        word_valid;
    logic        aligned;

    always #10 clk = ~clk;

    adc_word_deser uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ddr_bits   (ddr_bits),
        .frame_in   (frame_in),
        .train_en   (train_en),
        .word_out   (word_out),
        .word_valid (word_valid),
        .aligned    (aligned)
    );

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    int wd_fail = 0;
    logic [11:0] exp_q [16];
    int wr_idx = 0;
    int rd_idx = 0;
    logic [11:0] rec_word [64];
    logic        rec_al [64];
    int rec_n = 0;
    int bb_cnt = 0;
    logic prev_valid = 1'b0;

    // Monitor: records every presented word, compares queued expectations (R1 R2)
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (prev_valid) bb_cnt++;
            if (rec_n < 64) begin
                rec_word[rec_n] = word_out;
                rec_al[rec_n]   = aligned;
            end
            rec_n++;
            if (rd_idx < wr_idx) begin
                m_chk++;
                if (word_out !== exp_q[rd_idx]) begin
                    m_fail++;
                    $display("FAIL R1 R2 vector %0d: actual %h expected %h",
                             rd_idx, word_out, exp_q[rd_idx]);
                end
                rd_idx++;
            end
        end
        prev_valid = rst_n && word_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_chk + m_chk + wd_fail, n_fail + m_fail + wd_fail);
    endtask

    task automatic drive_pair(input logic [1:0] b, input logic fr);
        @(negedge clk);
        ddr_bits = b;
        frame_in = fr;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ddr_bits = '0;
        frame_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_word(input logic [11:0] w);
        for (int k = 0; k < 6; k++) drive_pair(w[11-2*k -: 2], k < 3);
    endtask

    function automatic logic [11:0] rotl(input logic [11:0] w, input int k);
        int s = k % 12;
        logic [11:0] r;
        if (s == 0) r = w;
        else        r = (w << s) | (w >> (12 - s));
        return r;
    endfunction

    function automatic logic sbit(input int t, input int sk);
        return PAT[11 - ((t + sk) % 12)];
    endfunction

    // Continuous pattern stream, data ahead of the frame by sk bits;
    // frame word `bad` is sent inverted.
    task automatic run_stream(input int sk, input int nwords, input int bad);
        for (int p = 0; p < nwords * 6; p++) begin
            logic inv = ((p / 6) == bad);
            drive_pair({sbit(2*p, sk) ^ inv, sbit(2*p + 1, sk) ^ inv}, (p % 6) < 3);
        end
        repeat (3) drive_pair(2'b00, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        wd_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        // Reset state (R10)
        do_reset();
        check(word_valid == 1'b0, "R10 valid after reset", word_valid, 0);
        check(word_out == 12'h000, "R10 word after reset", word_out, 0);
        check(aligned == 1'b0, "R10 aligned after reset", aligned, 0);

        // No words before the first frame rise (R6)
        base = rec_n;
        repeat (20) drive_pair(2'b10, 1'b0);
        check(rec_n == base, "R6 words before frame", rec_n - base, 0);

        // Vector table walk (R1 R2 R3 R4), then a cut-short word (R5)
        base = rec_n;
        foreach (VEC[i]) begin
            exp_q[wr_idx] = VEC[i].expect_w;
            wr_idx++;
            send_word(VEC[i].stim);
        end
        drive_pair(2'b11, 1'b1);
        drive_pair(2'b01, 1'b0);
        exp_q[wr_idx] = 12'h9E4;
        wr_idx++;
        send_word(12'h9E4);
        repeat (3) drive_pair(2'b00, 1'b0);
        check(rd_idx == wr_idx, "R3 expected words seen", rd_idx, wr_idx);
        check(rec_n - base == 9, "R5 partial word dropped", rec_n - base, 9);
        check(word_out == 12'h9E4, "R3 word held after strobe", word_out, 12'h9E4);

        // Training off: no slip, no lock (R7)
        do_reset();
        train_en = 1'b0;
        base = rec_n;
        run_stream(5, 4, -1);
        check(rec_n - base == 4, "R7 word count", rec_n - base, 4);
        for (int i = 0; i < 4; i++)
            check(rec_word[base+i] == rotl(PAT, 5), "R7 offset unchanged",
                  rec_word[base+i], rotl(PAT, 5));
        check(aligned == 1'b0, "R7 aligned stays low", aligned, 0);

        // Training: slip per mismatch, lock after eight matches, loss on error (R8 R9)
        do_reset();
        train_en = 1'b1;
        base = rec_n;
        run_stream(5, 18, 16);
        check(rec_n - base == 18, "R8 word count", rec_n - base, 18);
        for (int i = 0; i <= 5; i++)
            check(rec_word[base+i] == rotl(PAT, 5 - i), "R8 one-bit slip per mismatch",
                  rec_word[base+i], rotl(PAT, 5 - i));
        check(rec_al[base+11] == 1'b0, "R9 not locked after seven matches", rec_al[base+11], 0);
        check(rec_al[base+12] == 1'b1, "R9 locked at eighth match", rec_al[base+12], 1);
        check(rec_al[base+15] == 1'b1, "R9 lock held on matches", rec_al[base+15], 1);
        check(rec_al[base+16] == 1'b0, "R8 mismatch clears aligned", rec_al[base+16], 0);

        // Reset while locked clears lock and offset (R10)
        do_reset();
        train_en = 1'b1;
        run_stream(5, 13, -1);
        check(aligned == 1'b1, "R9 locked before reset", aligned, 1);
        train_en = 1'b0;
        do_reset();
        check(aligned == 1'b0, "R10 reset clears aligned", aligned, 0);
        check(word_out == 12'h000, "R10 reset clears word", word_out, 0);
        base = rec_n;
        run_stream(5, 3, -1);
        check(rec_n - base == 3, "R10 word count after reset", rec_n - base, 3);
        check(rec_word[base] == rotl(PAT, 5), "R10 offset back to zero",
              rec_word[base], rotl(PAT, 5));

        check(bb_cnt == 0, "R3 back-to-back strobes", bb_cnt, 0);
        summary();
        $finish;
    end

endmodule